// File: doc/BRIEF.md
# Multi-Bucket Correlated Double Sampling Row Readout Sequencer

This block drives the readout of one addressed pixel row whose pixels each hold several charge buckets. Exposure has already ended when it runs. It reads the row once for each bucket the request names. Each read starts by pulsing the floating-diffusion reset and letting the node settle. The sequencer then strobes the reset-level sample and lowers the storage gate of the chosen bucket so its charge spills onto the floating diffusion. Last, it strobes the signal-level sample. While one bucket is being read, every other bucket's storage gate stays at the middle (storage) level, so the repeated resets of the floating diffusion leave their charge untouched.

Requests arrive on a valid/ready port. Each request carries a row address, a bucket count and five phase lengths, and all of them are captured when the request is accepted. The block holds one accepted request while a readout is running, and req_ready tells the sender whether that slot is free. A sender with req_valid high must keep its fields steady until it sees req_ready high at a clock edge. Nothing is lost when req_ready is low; the request simply waits. Analog subtraction and conversion happen outside this block. A bucket-count code larger than the number of buckets built in is read as the largest count.

Top module: `cds_row_sequencer`

## Requirements
- R1: After reset, row_sel, fd_rst, shr, shs and row_done are 0, row_addr and bkt_idx are 0, req_ready is 1, and every bucket's gate code is MID (2'b01).
- R2: A request is accepted at a clock edge where req_valid and req_ready are both 1. With the sequencer idle, fd_rst goes high after the second clock edge following acceptance. The field req_bcnt holds the bucket count minus one. The row, count and phase lengths are taken from the request at acceptance, and later changes on those inputs do not affect that readout.
- R3: Each bucket read runs these phases in order: fd_rst high for T_rst cycles, a settle phase of T_set cycles with every strobe low, shr high for T_shr cycles, the transfer phase of T_xfer cycles, and shs high for T_shs cycles. A programmed length of 0 acts as 1.
- R4: shr and shs are never high in the same cycle. Neither is high while fd_rst is high or while any gate is at LOW.
- R5: Gate codes are LOW=2'b00 and MID=2'b01, and bucket g's code sits at sg_level[2g+1:2g]. During a transfer phase, only the bucket being read is at LOW. At every other time, every bucket is at MID, and HIGH (2'b10) is never driven.
- R6: Buckets are read in ascending order from 0 to count-1. bkt_idx shows the bucket being read while row_sel is high and reads 0 otherwise.
- R7: row_sel is high from the first fd_rst cycle of bucket 0 through the last shs cycle of the last bucket. row_addr equals the request's row while row_sel is high and is 0 otherwise.
- R8: row_done is high for exactly one cycle, right after the last shs cycle of the row, with row_sel low in that cycle.
- R9: While a readout runs, one further request can be accepted, and req_ready is 0 as long as that request is held. The held request starts with fd_rst high in the cycle right after row_done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Row-read request valid |
| req_ready | output | 1 | Holding slot free; request accepted when both valid and ready are high |
| req_row | input | ROW_W | Row address to read |
| req_bcnt | input | BIDX_W | Number of buckets to read, minus one |
| dur_rst | input | DUR_W | Reset phase length in cycles |
| dur_settle | input | DUR_W | Settle phase length in cycles |
| dur_shr | input | DUR_W | Reset-sample strobe length in cycles |
| dur_xfer | input | DUR_W | Transfer phase length in cycles |
| dur_shs | input | DUR_W | Signal-sample strobe length in cycles |
| row_sel | output | 1 | Row select, high across the whole row readout |
| row_addr | output | ROW_W | Address of the row being read, 0 when idle |
| fd_rst | output | 1 | Floating-diffusion reset |
| shr | output | 1 | Reset-level sample strobe |
| shs | output | 1 | Signal-level sample strobe |
| sg_level | output | 2*NUM_BUCKETS | Per-bucket storage gate level codes |
| bkt_idx | output | BIDX_W | Bucket being read |
| row_done | output | 1 | One-cycle pulse at the end of the row |

## Verification
The bound assertions check the ordering invariants on every cycle. Each check looks at a separate rule: the two strobes never overlap, neither strobe fires during reset or transfer, at most one gate is LOW and it is the one bkt_idx names, HIGH is never driven, row_sel covers all activity, and every shs rise and row_done pulse comes right after the phase that must precede it. Exact phase lengths, the treatment of zero lengths, the bucket order, the row address and the latency from acceptance can only be shown by the bench. It sweeps bucket counts and length sets and compares every output in every cycle against an arithmetic schedule. The bench also shows the holding of a second request during a readout, the back-pressure on a third, and their service in order.

// File: rtl/cds_seq_pkg.sv
`timescale 1ns/1ps
package cds_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_RST    = 3'd1,
    PH_SETTLE = 3'd2,
    PH_SHR    = 3'd3,
    PH_XFER   = 3'd4,
    PH_SHS    = 3'd5,
    PH_DONE   = 3'd6
  } phase_e;

  // storage gate level codes
  localparam logic [1:0] SG_LOW = 2'b00;
  localparam logic [1:0] SG_MID = 2'b01;

  // slot order of the packed phase-length vector
  localparam int DI_RST = 0;
  localparam int DI_SET = 1;
  localparam int DI_SHR = 2;
  localparam int DI_XFR = 3;
  localparam int DI_SHS = 4;
  localparam int N_DUR  = 5;
endpackage

// File: rtl/cds_req_slot.sv
`timescale 1ns/1ps
module cds_req_slot #(
  parameter int ROW_W  = 10,
  parameter int BIDX_W = 2,
  parameter int DUR_W  = 8,
  parameter int N_DUR  = 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [ROW_W-1:0]       in_row,
  input  logic [BIDX_W-1:0]      in_bcnt,
  input  logic [N_DUR*DUR_W-1:0] in_dur,
  input  logic                   pop,
  output logic                   full,
  output logic [ROW_W-1:0]       out_row,
  output logic [BIDX_W-1:0]      out_bcnt,
  output logic [N_DUR*DUR_W-1:0] out_dur
);
  logic push;

  assign in_ready = !full;
  assign push     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full     <= 1'b0;
      out_row  <= '0;
      out_bcnt <= '0;
      out_dur  <= '0;
    end else begin
      if (push) begin
        full     <= 1'b1;
        out_row  <= in_row;
        out_bcnt <= in_bcnt;
        out_dur  <= in_dur;
      end else if (pop) begin
        full <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cds_phase_timer.sv
`timescale 1ns/1ps
module cds_phase_timer #(
  parameter int DUR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DUR_W-1:0] len,
  output logic             expired
);
  logic [DUR_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (load) begin
      // a length of zero behaves like one cycle
      cnt <= (len == '0) ? '0 : len - DUR_W'(1);
    end else if (cnt != '0) begin
      cnt <= cnt - DUR_W'(1);
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/cds_gate_driver.sv
`timescale 1ns/1ps
module cds_gate_driver
  import cds_seq_pkg::*;
#(
  parameter int NUM_BUCKETS = 4,
  parameter int BIDX_W      = 2
) (
  input  logic                     xfer_en,
  input  logic [BIDX_W-1:0]        sel,
  output logic [2*NUM_BUCKETS-1:0] sg_level
);
  for (genvar g = 0; g < NUM_BUCKETS; g++) begin : g_gate
    assign sg_level[2*g +: 2] = (xfer_en && (sel == BIDX_W'(g))) ? SG_LOW : SG_MID;
  end
endmodule

// File: rtl/cds_row_sequencer.sv
`timescale 1ns/1ps
module cds_row_sequencer
  import cds_seq_pkg::*;
#(
  parameter int NUM_BUCKETS = 4,
  parameter int ROW_W       = 10,
  parameter int DUR_W       = 8,
  localparam int BIDX_W     = (NUM_BUCKETS > 1) ? $clog2(NUM_BUCKETS) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ROW_W-1:0]         req_row,
  input  logic [BIDX_W-1:0]        req_bcnt,
  input  logic [DUR_W-1:0]         dur_rst,
  input  logic [DUR_W-1:0]         dur_settle,
  input  logic [DUR_W-1:0]         dur_shr,
  input  logic [DUR_W-1:0]         dur_xfer,
  input  logic [DUR_W-1:0]         dur_shs,
  output logic                     row_sel,
  output logic [ROW_W-1:0]         row_addr,
  output logic                     fd_rst,
  output logic                     shr,
  output logic                     shs,
  output logic [2*NUM_BUCKETS-1:0] sg_level,
  output logic [BIDX_W-1:0]        bkt_idx,
  output logic                     row_done
);
  localparam int  DV_W = N_DUR * DUR_W;
  localparam bit  POW2 = ((1 << BIDX_W) == NUM_BUCKETS);

  logic [DV_W-1:0]   req_dur;
  logic              s_full;
  logic [ROW_W-1:0]  s_row;
  logic [BIDX_W-1:0] s_bcnt;
  logic [BIDX_W-1:0] s_last;
  logic [DV_W-1:0]   s_dur;
  logic              start;

  phase_e            ph, ph_n;
  logic [ROW_W-1:0]  act_row;
  logic [BIDX_W-1:0] act_last;
  logic [DV_W-1:0]   act_dur;
  logic [BIDX_W-1:0] bidx, bidx_n;
  logic              t_load;
  logic [DUR_W-1:0]  t_len;
  logic              t_exp;

  assign req_dur = {dur_shs, dur_xfer, dur_shr, dur_settle, dur_rst};

  cds_req_slot #(
    .ROW_W (ROW_W),
    .BIDX_W(BIDX_W),
    .DUR_W (DUR_W),
    .N_DUR (N_DUR)
  ) u_slot (
    .clk     (clk),
    .rst_n   (rst_n),
    .in_valid(req_valid),
    .in_ready(req_ready),
    .in_row  (req_row),
    .in_bcnt (req_bcnt),
    .in_dur  (req_dur),
    .pop     (start),
    .full    (s_full),
    .out_row (s_row),
    .out_bcnt(s_bcnt),
    .out_dur (s_dur)
  );

  // bucket-count clamp only exists when not every code is a legal count
  if (POW2) begin : g_cnt_pass
    assign s_last = s_bcnt;
  end else begin : g_cnt_clamp
    assign s_last = (s_bcnt > BIDX_W'(NUM_BUCKETS - 1)) ? BIDX_W'(NUM_BUCKETS - 1) : s_bcnt;
  end

  assign start = ((ph == PH_IDLE) || (ph == PH_DONE)) && s_full;

  cds_phase_timer #(.DUR_W(DUR_W)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (t_load),
    .len    (t_len),
    .expired(t_exp)
  );

  always_comb begin
    ph_n   = ph;
    bidx_n = bidx;
    t_load = 1'b0;
    t_len  = '0;
    unique case (ph)
      PH_IDLE, PH_DONE: begin
        bidx_n = '0;
        if (s_full) begin
          ph_n   = PH_RST;
          t_load = 1'b1;
          t_len  = s_dur[DI_RST*DUR_W +: DUR_W];
        end else begin
          ph_n = PH_IDLE;
        end
      end
      PH_RST: if (t_exp) begin
        ph_n   = PH_SETTLE;
        t_load = 1'b1;
        t_len  = act_dur[DI_SET*DUR_W +: DUR_W];
      end
      PH_SETTLE: if (t_exp) begin
        ph_n   = PH_SHR;
        t_load = 1'b1;
        t_len  = act_dur[DI_SHR*DUR_W +: DUR_W];
      end
      PH_SHR: if (t_exp) begin
        ph_n   = PH_XFER;
        t_load = 1'b1;
        t_len  = act_dur[DI_XFR*DUR_W +: DUR_W];
      end
      PH_XFER: if (t_exp) begin
        ph_n   = PH_SHS;
        t_load = 1'b1;
        t_len  = act_dur[DI_SHS*DUR_W +: DUR_W];
      end
      PH_SHS: if (t_exp) begin
        if (bidx == act_last) begin
          ph_n = PH_DONE;
        end else begin
          ph_n   = PH_RST;
          bidx_n = bidx + BIDX_W'(1);
          t_load = 1'b1;
          t_len  = act_dur[DI_RST*DUR_W +: DUR_W];
        end
      end
      default: ph_n = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      bidx     <= '0;
      act_row  <= '0;
      act_last <= '0;
      act_dur  <= '0;
    end else begin
      ph   <= ph_n;
      bidx <= bidx_n;
      if (start) begin
        act_row  <= s_row;
        act_last <= s_last;
        act_dur  <= s_dur;
      end
    end
  end

  cds_gate_driver #(
    .NUM_BUCKETS(NUM_BUCKETS),
    .BIDX_W     (BIDX_W)
  ) u_gates (
    .xfer_en (ph == PH_XFER),
    .sel     (bidx),
    .sg_level(sg_level)
  );

  assign row_sel  = (ph == PH_RST) || (ph == PH_SETTLE) || (ph == PH_SHR) ||
                    (ph == PH_XFER) || (ph == PH_SHS);
  assign fd_rst   = (ph == PH_RST);
  assign shr      = (ph == PH_SHR);
  assign shs      = (ph == PH_SHS);
  assign row_done = (ph == PH_DONE);
  assign row_addr = row_sel ? act_row : '0;
  assign bkt_idx  = row_sel ? bidx : '0;
endmodule

// File: rtl/cds_row_sequencer_checker.sv
`timescale 1ns/1ps
module cds_row_sequencer_checker
  import cds_seq_pkg::*;
#(
  parameter int NUM_BUCKETS = 4,
  parameter int BIDX_W      = 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     row_sel,
  input logic                     fd_rst,
  input logic                     shr,
  input logic                     shs,
  input logic [2*NUM_BUCKETS-1:0] sg_level,
  input logic [BIDX_W-1:0]        bkt_idx,
  input logic                     row_done
);
  logic [NUM_BUCKETS-1:0] low_mask;
  logic [NUM_BUCKETS-1:0] legal_mask;

  for (genvar g = 0; g < NUM_BUCKETS; g++) begin : g_dec
    assign low_mask[g]   = (sg_level[2*g +: 2] == SG_LOW);
    assign legal_mask[g] = (sg_level[2*g +: 2] == SG_LOW) || (sg_level[2*g +: 2] == SG_MID);
  end

  p_strobe_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(shr && shs));

  p_strobe_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (shr || shs) |-> (!fd_rst && (low_mask == '0)));

  p_one_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(low_mask));

  p_no_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (&legal_mask));

  p_low_is_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|low_mask) |-> (low_mask == (NUM_BUCKETS'(1) << bkt_idx)));

  p_rowsel_cover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fd_rst || shr || shs || (|low_mask)) |-> row_sel);

  p_shs_after_xfer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shs) |-> $past(|low_mask));

  p_shr_after_release_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(shr) |-> !$past(fd_rst));

  p_done_after_shs_r8: assert property (@(posedge clk) disable iff (!rst_n)
    row_done |-> ($past(shs) && !row_sel));
endmodule

bind cds_row_sequencer cds_row_sequencer_checker #(
  .NUM_BUCKETS(NUM_BUCKETS),
  .BIDX_W     (BIDX_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .row_sel (row_sel),
  .fd_rst  (fd_rst),
  .shr     (shr),
  .shs     (shs),
  .sg_level(sg_level),
  .bkt_idx (bkt_idx),
  .row_done(row_done)
);

// File: tb/cds_row_sequencer_bench.sv
`timescale 1ns/1ps
module cds_row_sequencer_bench;
  localparam int NB    = 4;
  localparam int ROW_W = 6;
  localparam int DUR_W = 4;
  localparam int BW    = 2;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [ROW_W-1:0]  req_row = '0;
  logic [BW-1:0]     req_bcnt = '0;
  logic [DUR_W-1:0]  dur_rst = '0, dur_settle = '0, dur_shr = '0, dur_xfer = '0, dur_shs = '0;
  logic              row_sel, fd_rst, shr, shs, row_done;
  logic [ROW_W-1:0]  row_addr;
  logic [2*NB-1:0]   sg_level;
  logic [BW-1:0]     bkt_idx;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  cds_row_sequencer #(.NUM_BUCKETS(NB), .ROW_W(ROW_W), .DUR_W(DUR_W)) u_cds_row_sequencer (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_bcnt(req_bcnt), .dur_rst(dur_rst), .dur_settle(dur_settle),
    .dur_shr(dur_shr), .dur_xfer(dur_xfer), .dur_shs(dur_shs), .row_sel(row_sel),
    .row_addr(row_addr), .fd_rst(fd_rst), .shr(shr), .shs(shs), .sg_level(sg_level),
    .bkt_idx(bkt_idx), .row_done(row_done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic put_fields(input int row, input int nb, input int r, input int s,
                            input int h, input int x, input int g);
    req_row    = ROW_W'(row);
    req_bcnt   = BW'(nb - 1);
    dur_rst    = DUR_W'(r);
    dur_settle = DUR_W'(s);
    dur_shr    = DUR_W'(h);
    dur_xfer   = DUR_W'(x);
    dur_shs    = DUR_W'(g);
  endtask

  // returns just after the accepting clock edge
  task automatic send_req(input int row, input int nb, input int r, input int s,
                          input int h, input int x, input int g);
    @(negedge clk);
    req_valid = 1'b1;
    put_fields(row, nb, r, s, h, x, g);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    put_fields(0, 1, 0, 0, 0, 0, 0); // R2: later input changes must not matter
  endtask

  // call just after the edge preceding the first reset cycle
  task automatic check_read(input int row, input int nb, input int r, input int s,
                            input int h, input int x, input int g);
    int er, es, eh, ex, eg, per, tot, k, b, o, ph;
    logic [2*NB-1:0] esg;
    er = eff(r); es = eff(s); eh = eff(h); ex = eff(x); eg = eff(g);
    per = er + es + eh + ex + eg;
    tot = nb * per;
    for (int c = 1; c <= tot + 1; c++) begin
      @(posedge clk);
      @(negedge clk);
      if (c == tot + 1) begin
        ph = 5; b = 0;
      end else begin
        k = c - 1; b = k / per; o = k % per;
        if (o < er) ph = 0;
        else if (o < er + es) ph = 1;
        else if (o < er + es + eh) ph = 2;
        else if (o < er + es + eh + ex) ph = 3;
        else ph = 4;
      end
      for (int q = 0; q < NB; q++)
        esg[2*q +: 2] = (ph == 3 && q == b) ? 2'b00 : 2'b01;
      chk(fd_rst == (ph == 0), "R3 fd_rst phase", int'(fd_rst), int'(ph == 0));
      chk(shr == (ph == 2), "R3/R4 shr phase", int'(shr), int'(ph == 2));
      chk(shs == (ph == 4), "R3/R4 shs phase", int'(shs), int'(ph == 4));
      chk(sg_level == esg, "R5 gate levels", int'(sg_level), int'(esg));
      chk(row_sel == (ph < 5), "R7 row_sel", int'(row_sel), int'(ph < 5));
      chk(int'(row_addr) == ((ph < 5) ? row : 0), "R7 row_addr", int'(row_addr), (ph < 5) ? row : 0);
      chk(int'(bkt_idx) == b, "R6 bucket index", int'(bkt_idx), b);
      chk(row_done == (ph == 5), "R8 row_done", int'(row_done), int'(ph == 5));
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!row_sel && !fd_rst && !shr && !shs && !row_done, "R1 strobes in reset",
        int'({row_sel, fd_rst, shr, shs, row_done}), 0);
    chk(sg_level == {NB{2'b01}}, "R1 gates MID in reset", int'(sg_level), int'({NB{2'b01}}));
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", int'(req_ready), 1);
    chk(row_addr == '0 && bkt_idx == '0, "R1 address and index", int'({row_addr, bkt_idx}), 0);

    // sweep of bucket counts and phase lengths (R2..R8)
    for (int nb = 1; nb <= NB; nb++) begin
      for (int d = 0; d <= 3; d++) begin
        send_req(nb * 4 + d, nb, d, d, d, d, d);
        check_read(nb * 4 + d, nb, d, d, d, d, d);
      end
      send_req(40 + nb, nb, 2, 1, 3, 2, 1);
      check_read(40 + nb, nb, 2, 1, 3, 2, 1);
      send_req(50 + nb, nb, 1, 3, 0, 4, 2);
      check_read(50 + nb, nb, 1, 3, 0, 4, 2);
      @(negedge clk);
      chk(!row_done && !row_sel, "R8 single done pulse", int'({row_done, row_sel}), 0);
    end

    // R2: latency from acceptance when idle
    send_req(7, 1, 1, 1, 1, 1, 1);
    @(negedge clk);
    chk(!fd_rst && !row_sel, "R2 no start on first edge", int'({fd_rst, row_sel}), 0);
    @(negedge clk);
    chk(fd_rst == 1'b1, "R2 reset on second edge", int'(fd_rst), 1);
    repeat (6) @(negedge clk);

    // R9: hold one request during a readout, back-pressure another
    send_req(11, 2, 1, 1, 1, 1, 1);
    fork
      begin
        check_read(11, 2, 1, 1, 1, 1, 1);
        check_read(22, 4, 2, 0, 1, 3, 1);
      end
      begin
        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R9 ready while busy, slot empty", int'(req_ready), 1);
        send_req(22, 4, 2, 0, 1, 3, 1);
        @(negedge clk);
        req_valid = 1'b1;
        put_fields(33, 1, 3, 2, 2, 2, 2);
        chk(req_ready == 1'b0, "R9 ready low while held", int'(req_ready), 0);
        while (!req_ready) @(negedge clk);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        put_fields(0, 1, 0, 0, 0, 0, 0);
      end
    join
    check_read(33, 1, 3, 2, 2, 2, 2);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule